// File: doc/BRIEF.md
# Receiver Frequency-Correction Supervisor

This block steers the local-oscillator correction of an FSK receiver. Each clock cycle it reads a signed frequency error sample (1 kHz per LSB) and applies a proportional-integral update to a signed correction word. Both loop gains are set as shift counts. A two-bit mode input selects one of four loop behaviours: free running, switched off, paused, or lock. In lock mode the correction is frozen by qualified preamble or sync events and released again by end-of-preamble, end-of-packet, return-to-idle and receive-reissue strobes.

The correction magnitude is clamped to a pull-in range that follows the IF bandwidth code. When the loop freezes on a lock, a readback register captures the correction value as the measured carrier offset, and a valid flag is raised. The flag stays set until a new receive session begins.

The lock sequencer has four states. ST_TRACK means the loop is tracking. ST_PRE_HOLD means the loop is frozen on a preamble and waiting for sync. ST_SYNC_WAIT is the single cycle after the preamble ends, in which a sync word must arrive. ST_PKT_LOCK means the lock is confirmed. The transitions are:
- TRACK→PRE_HOLD: on a preamble qualification while preamble detection is on.
- TRACK→PKT_LOCK: on a sync qualification while preamble detection is off.
- PRE_HOLD→PKT_LOCK: on sync.
- PRE_HOLD→SYNC_WAIT: on the end of the preamble.
- SYNC_WAIT→PKT_LOCK: on sync.
- SYNC_WAIT→TRACK: when no sync arrives.
- PKT_LOCK→TRACK: on end of packet in packet mode, or on return to idle in streaming mode.
- Any state→TRACK: on a receive reissue, or when the mode is not lock.

Top module: `afc_lock_ctrl`

## Requirements
- R1: In mode 0 (free running), every cycle computes integ' = clamp(integ + (err >>> ki_shift)) and corr' = clamp(integ' + (err >>> kp_shift)). The shifts are arithmetic. corr_out shows corr' one clock after err_in is sampled.
- R2: In mode 1 (off), the integrator and corr_out become zero on the next clock, and afc_frozen is low.
- R3: In mode 2 (paused), corr_out and the integrator keep their values.
- R4: In mode 3 (lock) with pre_det_en high, a pre_qual in ST_TRACK still lets that cycle's update land. The correction is then frozen (afc_frozen high) from the next cycle on.
- R5: After pre_end in ST_PRE_HOLD, the sync word must arrive in the following cycle. If it does not, the lock is dropped and tracking resumes. If it does, or if sync arrives during the hold, the lock is confirmed.
- R6: In mode 3 with pre_det_en low, pre_qual has no effect and sync_qual freezes the correction.
- R7: In packet mode (packet_mode high), a confirmed lock ignores phy_idle and is released by pkt_end.
- R8: In streaming mode (packet_mode low), a confirmed lock ignores pkt_end and is released by phy_idle or rx_cmd.
- R9: |corr_out| never exceeds the pull-in limit set by bw_sel. Codes 0, 1, 2 and 3 give 50, 75, 100 and 150 kHz.
- R10: On entry to any locked state, rb_err takes the frozen correction (two's complement, 1 kHz per LSB) and rb_valid rises. rb_err keeps this value after the lock is released.
- R11: rx_cmd releases any lock and clears rb_valid while rb_err keeps its value. It takes priority over all other strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | ERR_W | Signed frequency error sample, 1 kHz/LSB |
| mode | input | 2 | 0 free, 1 off, 2 pause, 3 lock |
| pre_det_en | input | 1 | Preamble detection enabled |
| packet_mode | input | 1 | 1 packet, 0 streaming |
| kp_shift | input | SH_W | Proportional gain shift |
| ki_shift | input | SH_W | Integral gain shift |
| bw_sel | input | 2 | IF bandwidth code selecting the pull-in limit |
| pre_qual | input | 1 | Qualified preamble strobe |
| sync_qual | input | 1 | Qualified sync word strobe |
| pre_end | input | 1 | End of preamble strobe |
| pkt_end | input | 1 | End of packet strobe |
| phy_idle | input | 1 | Return to idle PHY state strobe |
| rx_cmd | input | 1 | Receive command strobe |
| corr_out | output | CORR_W | Signed oscillator correction |
| afc_frozen | output | 1 | Correction frozen by a lock |
| rb_err | output | CORR_W | Readback of measured error |
| rb_valid | output | 1 | Readback holds a value from the current session |

## Verification
The loop arithmetic is swept over every bandwidth code and every pair of gain shifts from 0 to 3. It is driven with constant large positive and negative errors, which separate clamp behaviour from integration. An alternating error and a ramp are also applied; these separate arithmetic from logical shifting and expose sign handling. Directed lock sequences are run next: a preamble with no sync, a preamble followed by a timely sync, a sync-only lock, packet and streaming release with the ignored strobes applied, and rx_cmd coinciding with other strobes. Together they separate the release rules of each state, and they show that the readback survives a release while its valid flag does not.

// File: rtl/afc_pkg.sv
package afc_pkg;
    typedef enum logic [1:0] {
        AFC_FREE  = 2'd0,
        AFC_OFF   = 2'd1,
        AFC_PAUSE = 2'd2,
        AFC_LOCK  = 2'd3
    } afc_mode_e;

    typedef enum logic [1:0] {
        ST_TRACK     = 2'd0,
        ST_PRE_HOLD  = 2'd1,
        ST_SYNC_WAIT = 2'd2,
        ST_PKT_LOCK  = 2'd3
    } afc_state_e;
endpackage

// File: rtl/afc_pull_limit.sv
module afc_pull_limit #(
    parameter int CORR_W    = 10,
    parameter int PULL_UNIT = 25
) (
    input  logic [1:0]        bw_sel,
    output logic [CORR_W-1:0] limit
);
    // limits are PULL_UNIT times 2, 3, 4 and 6
    localparam int L0 = PULL_UNIT * 2;
    localparam int L1 = PULL_UNIT * 3;
    localparam int L2 = PULL_UNIT * 4;
    localparam int L3 = PULL_UNIT * 6;

    always_comb begin
        unique case (bw_sel)
            2'd0: limit = CORR_W'(L0);
            2'd1: limit = CORR_W'(L1);
            2'd2: limit = CORR_W'(L2);
            default: limit = CORR_W'(L3);
        endcase
    end
endmodule

// File: rtl/afc_pi_core.sv
module afc_pi_core #(
    parameter int ERR_W  = 10,
    parameter int CORR_W = 10,
    parameter int SH_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic [SH_W-1:0]          kp_shift,
    input  logic [SH_W-1:0]          ki_shift,
    input  logic [CORR_W-1:0]        limit,
    input  logic                     upd_en,
    input  logic                     clr,
    output logic signed [CORR_W-1:0] corr_q,
    output logic signed [CORR_W-1:0] corr_d
);
    localparam int WMAX  = (ERR_W > CORR_W) ? ERR_W : CORR_W;
    localparam int SUM_W = WMAX + 2;

    logic signed [SUM_W-1:0] e_ext, p_term, i_term, lim_s;
    logic signed [SUM_W-1:0] integ_q, integ_d, integ_n, corr_n;

    function automatic logic signed [SUM_W-1:0] clampv(
        input logic signed [SUM_W-1:0] v,
        input logic signed [SUM_W-1:0] l
    );
        if (v > l)
            return l;
        if (v < -l)
            return -l;
        return v;
    endfunction

    always_comb begin
        e_ext   = SUM_W'(err_in);
        lim_s   = $signed({{(SUM_W-CORR_W){1'b0}}, limit});
        i_term  = e_ext >>> ki_shift;
        p_term  = e_ext >>> kp_shift;
        integ_n = clampv(integ_q + i_term, lim_s);
        corr_n  = clampv(integ_n + p_term, lim_s);
        if (clr) begin
            integ_d = '0;
            corr_d  = '0;
        end else if (upd_en) begin
            integ_d = integ_n;
            corr_d  = corr_n[CORR_W-1:0];
        end else begin
            integ_d = integ_q;
            corr_d  = corr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q <= '0;
            corr_q  <= '0;
        end else begin
            integ_q <= integ_d;
            corr_q  <= corr_d;
        end
    end

    AST_CORR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_en) && !$past(clr) && $stable(limit)) |->
        ((corr_q <= $signed({1'b0, limit})) && (corr_q >= -$signed({1'b0, limit})))); // R9
endmodule

// File: rtl/afc_lock_fsm.sv
module afc_lock_fsm
    import afc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  afc_mode_e mode,
    input  logic      pre_det_en,
    input  logic      packet_mode,
    input  logic      pre_qual,
    input  logic      sync_qual,
    input  logic      pre_end,
    input  logic      pkt_end,
    input  logic      phy_idle,
    input  logic      rx_cmd,
    output logic      frozen,
    output logic      upd_en,
    output logic      clr,
    output logic      lock_entry
);
    afc_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_TRACK;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (mode != AFC_LOCK || rx_cmd) begin
            st_d = ST_TRACK;
        end else begin
            unique case (st_q)
                ST_TRACK: begin
                    if (pre_det_en && pre_qual)
                        st_d = ST_PRE_HOLD;
                    else if (!pre_det_en && sync_qual)
                        st_d = ST_PKT_LOCK;
                end
                ST_PRE_HOLD: begin
                    if (sync_qual)
                        st_d = ST_PKT_LOCK;
                    else if (pre_end)
                        st_d = ST_SYNC_WAIT;
                end
                ST_SYNC_WAIT: st_d = sync_qual ? ST_PKT_LOCK : ST_TRACK;
                ST_PKT_LOCK: begin
                    if (packet_mode ? pkt_end : phy_idle)
                        st_d = ST_TRACK;
                end
                default: st_d = ST_TRACK;
            endcase
        end
    end

    always_comb begin
        frozen     = (st_q != ST_TRACK);
        lock_entry = (st_q == ST_TRACK) && (st_d != ST_TRACK);
        clr        = (mode == AFC_OFF);
        unique case (mode)
            AFC_FREE:  upd_en = 1'b1;
            AFC_OFF:   upd_en = 1'b0;
            AFC_PAUSE: upd_en = 1'b0;
            default:   upd_en = (st_q == ST_TRACK);
        endcase
    end

    AST_PREAMBLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AFC_LOCK && st_q == ST_TRACK && pre_det_en && pre_qual && !rx_cmd)
        |=> (st_q == ST_PRE_HOLD)); // R4
    AST_NO_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AFC_LOCK && st_q == ST_SYNC_WAIT && !sync_qual)
        |=> (st_q == ST_TRACK)); // R5
    AST_PKT_IGNORES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == AFC_LOCK && st_q == ST_PKT_LOCK && packet_mode && !pkt_end && !rx_cmd)
        |=> (st_q == ST_PKT_LOCK)); // R7
endmodule

// File: rtl/afc_lock_ctrl.sv
module afc_lock_ctrl
    import afc_pkg::*;
#(
    parameter int ERR_W     = 10,
    parameter int CORR_W    = 10,
    parameter int SH_W      = 3,
    parameter int PULL_UNIT = 25
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic [1:0]               mode,
    input  logic                     pre_det_en,
    input  logic                     packet_mode,
    input  logic [SH_W-1:0]          kp_shift,
    input  logic [SH_W-1:0]          ki_shift,
    input  logic [1:0]               bw_sel,
    input  logic                     pre_qual,
    input  logic                     sync_qual,
    input  logic                     pre_end,
    input  logic                     pkt_end,
    input  logic                     phy_idle,
    input  logic                     rx_cmd,
    output logic signed [CORR_W-1:0] corr_out,
    output logic                     afc_frozen,
    output logic signed [CORR_W-1:0] rb_err,
    output logic                     rb_valid
);
    logic [CORR_W-1:0]        limit;
    logic                     upd_en, clr, lock_entry;
    logic signed [CORR_W-1:0] corr_d;
    afc_mode_e                mode_e;

    assign mode_e = afc_mode_e'(mode);

    afc_pull_limit #(.CORR_W(CORR_W), .PULL_UNIT(PULL_UNIT)) u_limit (
        .bw_sel (bw_sel),
        .limit  (limit)
    );

    afc_lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_e),
        .pre_det_en  (pre_det_en),
        .packet_mode (packet_mode),
        .pre_qual    (pre_qual),
        .sync_qual   (sync_qual),
        .pre_end     (pre_end),
        .pkt_end     (pkt_end),
        .phy_idle    (phy_idle),
        .rx_cmd      (rx_cmd),
        .frozen      (afc_frozen),
        .upd_en      (upd_en),
        .clr         (clr),
        .lock_entry  (lock_entry)
    );

    afc_pi_core #(.ERR_W(ERR_W), .CORR_W(CORR_W), .SH_W(SH_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_in   (err_in),
        .kp_shift (kp_shift),
        .ki_shift (ki_shift),
        .limit    (limit),
        .upd_en   (upd_en),
        .clr      (clr),
        .corr_q   (corr_out),
        .corr_d   (corr_d)
    );

    // readback: captures the value the correction freezes at
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_err   <= '0;
            rb_valid <= 1'b0;
        end else begin
            if (lock_entry)
                rb_err <= corr_d;
            if (rx_cmd)
                rb_valid <= 1'b0;
            else if (lock_entry)
                rb_valid <= 1'b1;
        end
    end

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |=> (corr_out == '0)); // R2
    AST_PAUSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |=> $stable(corr_out)); // R3
    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && afc_frozen) |=> $stable(corr_out)); // R4
    AST_RB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_valid) |-> (rb_err == corr_out && afc_frozen)); // R10
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_valid) |-> ($past(rx_cmd) && $stable(rb_err))); // R11
endmodule

// File: tb/afc_lock_ctrl_tb_top.sv
module afc_lock_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [9:0] err_in;
    logic [1:0] mode, bw_sel;
    logic pre_det_en, packet_mode;
    logic [2:0] kp_shift, ki_shift;
    logic pre_qual, sync_qual, pre_end, pkt_end, phy_idle, rx_cmd;
    logic signed [9:0] corr_out, rb_err;
    logic afc_frozen, rb_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_integ, m_corr, m_st, m_rb;
    bit m_rbv;
    int e_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    afc_lock_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .err_in(err_in), .mode(mode),
        .pre_det_en(pre_det_en), .packet_mode(packet_mode),
        .kp_shift(kp_shift), .ki_shift(ki_shift), .bw_sel(bw_sel),
        .pre_qual(pre_qual), .sync_qual(sync_qual), .pre_end(pre_end),
        .pkt_end(pkt_end), .phy_idle(phy_idle), .rx_cmd(rx_cmd),
        .corr_out(corr_out), .afc_frozen(afc_frozen),
        .rb_err(rb_err), .rb_valid(rb_valid)
    );

    assign err_in = e_drv[9:0];

    function automatic int lim_of(int b);
        case (b)
            0: return 50;
            1: return 75;
            2: return 100;
            default: return 150;
        endcase
    endfunction

    function automatic int clampi(int v, int l);
        if (v > l) return l;
        if (v < -l) return -l;
        return v;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // model of the requirements, applied at each rising edge
    task automatic model_step();
        int nst;
        int l;
        bit entry;
        l = lim_of(int'(bw_sel));
        if (mode == 2'd1) begin
            m_integ = 0;
            m_corr = 0;
        end else if (mode == 2'd0 || (mode == 2'd3 && m_st == 0)) begin
            m_integ = clampi(m_integ + (e_drv >>> ki_shift), l);
            m_corr = clampi(m_integ + (e_drv >>> kp_shift), l);
        end
        nst = m_st;
        if (mode != 2'd3 || rx_cmd) nst = 0;
        else case (m_st)
            0: if (pre_det_en && pre_qual) nst = 1;
               else if (!pre_det_en && sync_qual) nst = 3;
            1: if (sync_qual) nst = 3; else if (pre_end) nst = 2;
            2: nst = sync_qual ? 3 : 0;
            default: if (packet_mode ? pkt_end : phy_idle) nst = 0;
        endcase
        entry = (m_st == 0) && (nst != 0);
        if (entry) m_rb = m_corr;
        if (rx_cmd) m_rbv = 0;
        else if (entry) m_rbv = 1;
        m_st = nst;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, "corr_out", int'(corr_out), m_corr);
        check(cur_req, "afc_frozen", int'(afc_frozen), int'(m_st != 0));
        check(cur_req, "rb_valid", int'(rb_valid), int'(m_rbv));
        check(cur_req, "rb_err", int'(rb_err), m_rb);
        {pre_qual, sync_qual, pre_end, pkt_end, phy_idle, rx_cmd} = '0;
    endtask

    function automatic int pattern(int p, int n);
        case (p)
            0: return 300;
            1: return -300;
            2: return (n % 2) ? -45 : 61;
            default: return -100 + 23 * n;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        e_drv = 0; mode = 2'd0; bw_sel = 2'd3; pre_det_en = 1; packet_mode = 1;
        kp_shift = 0; ki_shift = 2;
        {pre_qual, sync_qual, pre_end, pkt_end, phy_idle, rx_cmd} = '0;
        m_integ = 0; m_corr = 0; m_st = 0; m_rb = 0; m_rbv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("reset", "corr_out", int'(corr_out), 0);
        check("reset", "rb_valid", int'(rb_valid), 0);
        check("reset", "afc_frozen", int'(afc_frozen), 0);

        // R1 / R9 sweep: all bandwidths, gain shifts 0..3, four patterns
        for (int b = 0; b < 4; b++)
            for (int kp = 0; kp < 4; kp++)
                for (int ki = 0; ki < 4; ki++)
                    for (int p = 0; p < 4; p++) begin
                        bw_sel = 2'(b); kp_shift = 3'(kp); ki_shift = 3'(ki);
                        cur_req = "R2"; mode = 2'd1; e_drv = 99; tick();
                        cur_req = (p < 2) ? "R9" : "R1"; mode = 2'd0;
                        for (int n = 0; n < 10; n++) begin
                            e_drv = pattern(p, n);
                            tick();
                        end
                    end

        // R3 pause keeps value under changing error
        bw_sel = 2'd3; kp_shift = 1; ki_shift = 2;
        mode = 2'd0; e_drv = 80; cur_req = "R1"; tick(); tick();
        cur_req = "R3"; mode = 2'd2;
        for (int n = 0; n < 4; n++) begin e_drv = -200 + 50 * n; tick(); end

        // R4 / R5: preamble lock, no sync after preamble end -> release
        mode = 2'd3; pre_det_en = 1; packet_mode = 1; e_drv = 20;
        cur_req = "R4"; tick(); tick();
        pre_qual = 1; tick();
        e_drv = -90; tick(); tick();
        cur_req = "R5"; pre_end = 1; tick();
        tick();              // window without sync
        tick(); tick();      // tracking again

        // R5 + R7: sync in window confirms, packet mode ignores phy_idle
        cur_req = "R5"; e_drv = 33; pre_qual = 1; tick();
        pre_end = 1; tick();
        sync_qual = 1; tick();
        cur_req = "R7"; e_drv = 120; phy_idle = 1; tick(); tick();
        pkt_end = 1; tick(); tick();

        // R10: readback kept after release
        cur_req = "R10"; tick();

        // R6: preamble detection off, pre_qual ignored, sync locks
        cur_req = "R6"; pre_det_en = 0; e_drv = -60;
        pre_qual = 1; tick(); tick();
        sync_qual = 1; tick(); e_drv = 140; tick();
        cur_req = "R11"; rx_cmd = 1; tick(); tick();

        // R8: streaming release by phy_idle and rx_cmd, pkt_end ignored
        cur_req = "R8"; packet_mode = 0; pre_det_en = 1; e_drv = 45;
        pre_qual = 1; tick(); sync_qual = 1; tick();
        pkt_end = 1; tick(); tick();
        phy_idle = 1; tick(); tick();
        pre_qual = 1; tick(); sync_qual = 1; tick();
        rx_cmd = 1; tick(); tick();

        // R11: rx_cmd wins over a qualifying strobe in the same cycle
        cur_req = "R11"; pre_qual = 1; rx_cmd = 1; tick(); tick();
        pre_qual = 1; tick(); rx_cmd = 1; sync_qual = 1; tick(); tick();

        // R2: switching off clears a frozen correction
        cur_req = "R2"; pre_qual = 1; tick(); mode = 2'd1; tick(); tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule